// File: doc/BRIEF.md
# Complete Projective Elliptic-Curve Point Adder

This block adds two points of a short Weierstrass curve y^2 = x^3 + b over a prime field. Both operands and the result are held in projective (X:Y:Z) form, so no field inversion is ever computed. The block uses a complete addition law for curves with a = 0. A single branch-free datapath therefore gives the correct group sum for distinct points, for a point added to itself, for a point added to its negative, and for sums involving the neutral element. There is no separate control path for any of these cases.

The datapath is a seven-stage pipeline. Six independent field products are computed in parallel in the two wide multiply stages. The two products by the curve constant 3b share a stage of their own. Cheap modular additions and subtractions fill the stages in between. A new operand pair can be presented on every clock cycle. A valid flag travels alongside the data, and there is no back-pressure.

The neutral element is written (0:1:0); any (0:k:0) with k nonzero is accepted as the same point. The prime, the field width and the precomputed constant 3b are parameters. Conversion to affine form is left to the consumer.

Top module: `ecp_complete_add`

## Requirements
- R1: `valid_o` rises exactly 7 clock cycles after a cycle in which `valid_i` was high. An operand pair is accepted on every cycle, including back-to-back cycles. When no input was valid 7 cycles earlier, `valid_o` stays low.
- R2: For two distinct points P and Q with Q not equal to -P, the output (X:Y:Z) has Z nonzero. It also satisfies X = x*Z and Y = y*Z mod p, where (x, y) is the affine sum P+Q.
- R3: When both operands are the same point, the output is the affine double 2P under the same relation as R2, through the same datapath.
- R4: When one operand is the negative of the other (equal x, y negated), the output is the neutral element: X = 0, Z = 0 and Y nonzero.
- R5: When either operand is the neutral element (0:k:0) and the other is a point P, the output equals P up to projective scaling.
- R6: When both operands are neutral elements, the output is a neutral element (X = 0, Z = 0, Y nonzero).
- R7: Every output coordinate presented with `valid_o` high is a canonical field element, strictly less than the prime p.
- R8: Scaling either operand by any nonzero factor (X, Y, Z all multiplied by k) leaves the output point unchanged up to projective scaling.
- R9: While `rst_ni` is low and until the first valid result, `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand pair present this cycle |
| p_x_i | input | FW | First operand X coordinate |
| p_y_i | input | FW | First operand Y coordinate |
| p_z_i | input | FW | First operand Z coordinate |
| q_x_i | input | FW | Second operand X coordinate |
| q_y_i | input | FW | Second operand Y coordinate |
| q_z_i | input | FW | Second operand Z coordinate |
| valid_o | output | 1 | Sum present this cycle |
| r_x_o | output | FW | Sum X coordinate |
| r_y_o | output | FW | Sum Y coordinate |
| r_z_o | output | FW | Sum Z coordinate |

## Verification
Two things can happen in the same cycle: a new pair enters the first stage while an older sum leaves the last stage. Also, pairs of different kinds (general sum, doubling, inverse, neutral operand) sit in adjacent stages at once. The bench provokes both by streaming a mixed sequence of such pairs on consecutive cycles with no gaps. Each emerging result is matched in order against an affine reference model of the group law, and its arrival cycle is checked against the issue cycle plus seven.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int unsigned FW_DEF = 31;
  localparam logic [FW_DEF-1:0] PRIME_DEF = 31'h7FFF_FFFF;  // 2^31-1
  localparam logic [FW_DEF-1:0] B3_DEF = 31'd21;            // 3*b, b = 7
  localparam int unsigned LAT = 7;
  localparam int unsigned N_WIDE = 6;                        // parallel products per wide stage
endpackage

// File: rtl/ecp_fp_add.sv
module ecp_fp_add #(
  parameter int unsigned W = 31,
  parameter logic [W-1:0] P = '1,
  parameter bit SUB = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  localparam logic [W:0] P_EXT = {1'b0, P};

  generate
    if (SUB) begin : g_sub
      assign r_o = (a_i >= b_i) ? (a_i - b_i) : W'({1'b0, a_i} + P_EXT - {1'b0, b_i});
    end else begin : g_add
      logic [W:0] sum;
      assign sum = {1'b0, a_i} + {1'b0, b_i};
      assign r_o = (sum >= P_EXT) ? W'(sum - P_EXT) : sum[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ecp_fp_mul.sv
module ecp_fp_mul #(
  parameter int unsigned W = 31,
  parameter logic [W-1:0] P = '1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  localparam int unsigned PW = 2 * W;
  localparam logic [PW-1:0] P_WIDE = PW'(P);

  logic [PW-1:0] prod;
  assign prod = PW'(a_i) * PW'(b_i);
  assign r_o  = W'(prod % P_WIDE);
endmodule

// File: rtl/ecp_complete_add.sv
module ecp_complete_add #(
  parameter int unsigned FW = ecp_pkg::FW_DEF,
  parameter logic [FW-1:0] PRIME = ecp_pkg::PRIME_DEF,
  parameter logic [FW-1:0] B3 = ecp_pkg::B3_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [FW-1:0] p_x_i,
  input  logic [FW-1:0] p_y_i,
  input  logic [FW-1:0] p_z_i,
  input  logic [FW-1:0] q_x_i,
  input  logic [FW-1:0] q_y_i,
  input  logic [FW-1:0] q_z_i,
  output logic          valid_o,
  output logic [FW-1:0] r_x_o,
  output logic [FW-1:0] r_y_o,
  output logic [FW-1:0] r_z_o
);
  localparam int unsigned LAT = ecp_pkg::LAT;
  localparam int unsigned NW = ecp_pkg::N_WIDE;
  localparam int unsigned NL = 4;              // ops per level in stage 3
  localparam logic [NL-1:0] L_SUB = 4'b0111;   // op 3 is an add (3*t0)
  localparam logic [2:0] OUT_SUB = 3'b001;     // X3 is a difference

  logic [LAT-1:0] vld_q;

  // ---------------- stage 1: operand sums ----------------
  logic [FW-1:0] s1a_a [NW];
  logic [FW-1:0] s1a_b [NW];
  logic [FW-1:0] s1a_r [NW];
  logic [FW-1:0] s1_pt [NW];   // x1 y1 z1 x2 y2 z2
  logic [FW-1:0] s1_sm [NW];   // x1+y1 x2+y2 y1+z1 y2+z2 x1+z1 x2+z2

  always_comb begin
    s1a_a[0] = p_x_i; s1a_b[0] = p_y_i;
    s1a_a[1] = q_x_i; s1a_b[1] = q_y_i;
    s1a_a[2] = p_y_i; s1a_b[2] = p_z_i;
    s1a_a[3] = q_y_i; s1a_b[3] = q_z_i;
    s1a_a[4] = p_x_i; s1a_b[4] = p_z_i;
    s1a_a[5] = q_x_i; s1a_b[5] = q_z_i;
  end

  for (genvar i = 0; i < NW; i++) begin : g_s1
    ecp_fp_add #(.W(FW), .P(PRIME), .SUB(1'b0)) u_add (
      .a_i(s1a_a[i]), .b_i(s1a_b[i]), .r_o(s1a_r[i])
    );
  end

  always_ff @(posedge clk_i) begin
    s1_pt[0] <= p_x_i; s1_pt[1] <= p_y_i; s1_pt[2] <= p_z_i;
    s1_pt[3] <= q_x_i; s1_pt[4] <= q_y_i; s1_pt[5] <= q_z_i;
    for (int i = 0; i < NW; i++) s1_sm[i] <= s1a_r[i];
  end

  // ---------------- stage 2: six parallel products ----------------
  logic [FW-1:0] s2m_a [NW];
  logic [FW-1:0] s2m_b [NW];
  logic [FW-1:0] s2m_r [NW];
  logic [FW-1:0] s2_m  [NW];   // t0 t1 t2 mxy myz mxz

  always_comb begin
    s2m_a[0] = s1_pt[0]; s2m_b[0] = s1_pt[3];
    s2m_a[1] = s1_pt[1]; s2m_b[1] = s1_pt[4];
    s2m_a[2] = s1_pt[2]; s2m_b[2] = s1_pt[5];
    s2m_a[3] = s1_sm[0]; s2m_b[3] = s1_sm[1];
    s2m_a[4] = s1_sm[2]; s2m_b[4] = s1_sm[3];
    s2m_a[5] = s1_sm[4]; s2m_b[5] = s1_sm[5];
  end

  for (genvar i = 0; i < NW; i++) begin : g_s2
    ecp_fp_mul #(.W(FW), .P(PRIME)) u_mul (
      .a_i(s2m_a[i]), .b_i(s2m_b[i]), .r_o(s2m_r[i])
    );
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NW; i++) s2_m[i] <= s2m_r[i];
  end

  // ---------------- stage 3: cross terms, two chained levels ----------------
  logic [FW-1:0] l1_a [NL];
  logic [FW-1:0] l1_b [NL];
  logic [FW-1:0] l1_r [NL];
  logic [FW-1:0] l2_b [NL];
  logic [FW-1:0] l2_r [NL];
  logic [FW-1:0] s3_t1, s3_t2, s3_u3, s3_u4, s3_v, s3_t03;

  always_comb begin
    l1_a[0] = s2_m[3]; l1_b[0] = s2_m[0]; l2_b[0] = s2_m[1];  // mxy-t0-t1
    l1_a[1] = s2_m[4]; l1_b[1] = s2_m[1]; l2_b[1] = s2_m[2];  // myz-t1-t2
    l1_a[2] = s2_m[5]; l1_b[2] = s2_m[0]; l2_b[2] = s2_m[2];  // mxz-t0-t2
    l1_a[3] = s2_m[0]; l1_b[3] = s2_m[0]; l2_b[3] = s2_m[0];  // 3*t0
  end

  for (genvar i = 0; i < NL; i++) begin : g_s3
    ecp_fp_add #(.W(FW), .P(PRIME), .SUB(L_SUB[i])) u_l1 (
      .a_i(l1_a[i]), .b_i(l1_b[i]), .r_o(l1_r[i])
    );
    ecp_fp_add #(.W(FW), .P(PRIME), .SUB(L_SUB[i])) u_l2 (
      .a_i(l1_r[i]), .b_i(l2_b[i]), .r_o(l2_r[i])
    );
  end

  always_ff @(posedge clk_i) begin
    s3_t1  <= s2_m[1];
    s3_t2  <= s2_m[2];
    s3_u3  <= l2_r[0];
    s3_u4  <= l2_r[1];
    s3_v   <= l2_r[2];
    s3_t03 <= l2_r[3];
  end

  // ---------------- stage 4: products by 3b ----------------
  logic [FW-1:0] k_t2, k_v;
  logic [FW-1:0] s4_t1, s4_u3, s4_u4, s4_t03, s4_t2b, s4_yb;

  ecp_fp_mul #(.W(FW), .P(PRIME)) u_k_t2 (.a_i(s3_t2), .b_i(B3), .r_o(k_t2));
  ecp_fp_mul #(.W(FW), .P(PRIME)) u_k_v  (.a_i(s3_v),  .b_i(B3), .r_o(k_v));

  always_ff @(posedge clk_i) begin
    s4_t1  <= s3_t1;
    s4_u3  <= s3_u3;
    s4_u4  <= s3_u4;
    s4_t03 <= s3_t03;
    s4_t2b <= k_t2;
    s4_yb  <= k_v;
  end

  // ---------------- stage 5: t1 +/- 3b*t2 ----------------
  logic [FW-1:0] c_z, c_w;
  logic [FW-1:0] s5_u3, s5_u4, s5_t03, s5_yb, s5_z, s5_w;

  ecp_fp_add #(.W(FW), .P(PRIME), .SUB(1'b0)) u_zs (.a_i(s4_t1), .b_i(s4_t2b), .r_o(c_z));
  ecp_fp_add #(.W(FW), .P(PRIME), .SUB(1'b1)) u_ws (.a_i(s4_t1), .b_i(s4_t2b), .r_o(c_w));

  always_ff @(posedge clk_i) begin
    s5_u3  <= s4_u3;
    s5_u4  <= s4_u4;
    s5_t03 <= s4_t03;
    s5_yb  <= s4_yb;
    s5_z   <= c_z;
    s5_w   <= c_w;
  end

  // ---------------- stage 6: six parallel products ----------------
  logic [FW-1:0] s6m_a [NW];
  logic [FW-1:0] s6m_b [NW];
  logic [FW-1:0] s6m_r [NW];
  logic [FW-1:0] s6_p  [NW];

  always_comb begin
    s6m_a[0] = s5_u4;  s6m_b[0] = s5_yb;   // X pair
    s6m_a[1] = s5_u3;  s6m_b[1] = s5_w;
    s6m_a[2] = s5_yb;  s6m_b[2] = s5_t03;  // Y pair
    s6m_a[3] = s5_w;   s6m_b[3] = s5_z;
    s6m_a[4] = s5_t03; s6m_b[4] = s5_u3;   // Z pair
    s6m_a[5] = s5_z;   s6m_b[5] = s5_u4;
  end

  for (genvar i = 0; i < NW; i++) begin : g_s6
    ecp_fp_mul #(.W(FW), .P(PRIME)) u_mul (
      .a_i(s6m_a[i]), .b_i(s6m_b[i]), .r_o(s6m_r[i])
    );
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NW; i++) s6_p[i] <= s6m_r[i];
  end

  // ---------------- stage 7: final combine ----------------
  logic [FW-1:0] o_a [3];
  logic [FW-1:0] o_b [3];
  logic [FW-1:0] o_r [3];

  always_comb begin
    o_a[0] = s6_p[1]; o_b[0] = s6_p[0];
    o_a[1] = s6_p[3]; o_b[1] = s6_p[2];
    o_a[2] = s6_p[5]; o_b[2] = s6_p[4];
  end

  for (genvar i = 0; i < 3; i++) begin : g_s7
    ecp_fp_add #(.W(FW), .P(PRIME), .SUB(OUT_SUB[i])) u_out (
      .a_i(o_a[i]), .b_i(o_b[i]), .r_o(o_r[i])
    );
  end

  always_ff @(posedge clk_i) begin
    r_x_o <= o_r[0];
    r_y_o <= o_r[1];
    r_z_o <= o_r[2];
  end

  // ---------------- valid pipeline ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end
  assign valid_o = vld_q[LAT-1];

  // ---------------- assertions ----------------
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= '0;
    else if (since_rst != 3'd7)   since_rst <= since_rst + 3'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd7) |-> (valid_o == $past(valid_i, 7)));  // R1

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd7) |-> !valid_o);  // R9

  AST_CANONICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (r_x_o < PRIME && r_y_o < PRIME && r_z_o < PRIME));  // R7

  AST_INF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd7 && $past(valid_i && p_x_i == '0 && p_z_i == '0 && p_y_i != '0
                                && q_x_i == '0 && q_z_i == '0 && q_y_i != '0, 7))
    |-> (r_x_o == '0 && r_z_o == '0 && r_y_o != '0));  // R6

  AST_NEG_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd7 && $past(valid_i && p_z_i != '0 && p_z_i == q_z_i && p_x_i == q_x_i
                                && p_y_i != '0 && q_y_i == PRIME - p_y_i, 7))
    |-> (r_z_o == '0 && r_x_o == '0));  // R4
endmodule

// File: tb/ecp_complete_add_bench.sv
module ecp_complete_add_bench;
  localparam int unsigned FW = 31;
  localparam longint unsigned PM = 64'h7FFF_FFFF;
  localparam longint unsigned BC = 7;

  typedef struct packed { logic [FW-1:0] x, y, z; } pt_t;
  typedef struct packed { logic inf; logic [FW-1:0] x, y; } aff_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [FW-1:0] p_x_i = '0, p_y_i = '0, p_z_i = '0;
  logic [FW-1:0] q_x_i = '0, q_y_i = '0, q_z_i = '0;
  logic valid_o;
  logic [FW-1:0] r_x_o, r_y_o, r_z_o;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  bit done = 0;

  aff_t exp_q[$];
  string req_q[$];
  int unsigned t_q[$];

  ecp_complete_add u_ecp_complete_add (
    .clk_i, .rst_ni, .valid_i,
    .p_x_i, .p_y_i, .p_z_i, .q_x_i, .q_y_i, .q_z_i,
    .valid_o, .r_x_o, .r_y_o, .r_z_o
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // ---------------- field reference ----------------
  function automatic longint unsigned fm(longint unsigned a, longint unsigned b);
    return (a * b) % PM;
  endfunction
  function automatic longint unsigned fa(longint unsigned a, longint unsigned b);
    return (a + b) % PM;
  endfunction
  function automatic longint unsigned fs(longint unsigned a, longint unsigned b);
    return (a + PM - b) % PM;
  endfunction
  function automatic longint unsigned fpow(longint unsigned b, longint unsigned e);
    longint unsigned r = 1;
    longint unsigned bb = b % PM;
    longint unsigned ee = e;
    while (ee != 0) begin
      if (ee[0]) r = fm(r, bb);
      bb = fm(bb, bb);
      ee = ee >> 1;
    end
    return r;
  endfunction
  function automatic longint unsigned finv(longint unsigned a);
    return fpow(a, PM - 2);
  endfunction

  function automatic aff_t find_point(longint unsigned x0);
    aff_t r;
    longint unsigned x = x0;
    longint unsigned rhs, y;
    r = '0;
    for (int i = 0; i < 200; i++) begin
      rhs = fa(fm(fm(x, x), x), BC);
      y = fpow(rhs, (PM + 1) / 4);
      if (y != 0 && fm(y, y) == rhs) begin
        r.x = FW'(x); r.y = FW'(y); r.inf = 1'b0;
        return r;
      end
      x = x + 1;
    end
    return r;
  endfunction

  function automatic aff_t neg(aff_t a);
    aff_t r = a;
    if (!a.inf) r.y = FW'(fs(0, a.y));
    return r;
  endfunction

  function automatic aff_t aff_add(aff_t a, aff_t b);
    aff_t r;
    longint unsigned lam, x3, y3;
    r = '0;
    if (a.inf) return b;
    if (b.inf) return a;
    if (a.x == b.x) begin
      if (a.y != b.y || a.y == 0) begin r.inf = 1'b1; return r; end
      lam = fm(fm(3, fm(a.x, a.x)), finv(fm(2, a.y)));
    end else begin
      lam = fm(fs(b.y, a.y), finv(fs(b.x, a.x)));
    end
    x3 = fs(fs(fm(lam, lam), a.x), b.x);
    y3 = fs(fm(lam, fs(a.x, x3)), a.y);
    r.inf = 1'b0; r.x = FW'(x3); r.y = FW'(y3);
    return r;
  endfunction

  function automatic pt_t to_proj(aff_t a, longint unsigned k);
    pt_t p;
    if (a.inf) begin p.x = '0; p.y = FW'(k); p.z = '0; end
    else begin p.x = FW'(fm(a.x, k)); p.y = FW'(fm(a.y, k)); p.z = FW'(k); end
    return p;
  endfunction

  // ---------------- reporting ----------------
  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- output monitor ----------------
  initial begin
    aff_t e;
    string rq;
    int unsigned t0;
    bit ok;
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1", "unexpected valid_o", 1, 0);
        end else begin
          e = exp_q.pop_front(); rq = req_q.pop_front(); t0 = t_q.pop_front();
          chk((cyc - t0) == 7, "R1", "latency", cyc - t0, 7);
          chk(r_x_o < PM && r_y_o < PM && r_z_o < PM, "R7", "canonical x", r_x_o, PM - 1);
          if (e.inf) begin
            ok = (r_z_o == 0) && (r_x_o == 0) && (r_y_o != 0);
            chk(ok, rq, "neutral z", r_z_o, 0);
          end else begin
            ok = (r_z_o != 0) && (r_x_o == fm(e.x, r_z_o)) && (r_y_o == fm(e.y, r_z_o));
            chk(ok, rq, "x vs z*x_ref", r_x_o, fm(e.x, r_z_o));
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(aff_t a, longint unsigned ka, aff_t b, longint unsigned kb, string req);
    pt_t pa, pb;
    pa = to_proj(a, ka); pb = to_proj(b, kb);
    valid_i = 1'b1;
    p_x_i = pa.x; p_y_i = pa.y; p_z_i = pa.z;
    q_x_i = pb.x; q_y_i = pb.y; q_z_i = pb.z;
    exp_q.push_back(aff_add(a, b)); req_q.push_back(req); t_q.push_back(cyc);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk_i);
    chk(exp_q.size() == 0, req, "results missing", exp_q.size(), 0);
    repeat (2) @(negedge clk_i);
  endtask

  aff_t pa, pb, pc, pd, oo;

  task automatic test_reset();
    chk(valid_o == 1'b0, "R9", "valid_o in reset", valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (9) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R9", "valid_o idle after reset", valid_o, 0);
    end
  endtask

  task automatic test_general();
    send(pa, 1, pb, 1, "R2");
    send(pc, 1, pd, 1, "R2");
    drain("R2");
  endtask

  task automatic test_double();
    send(pa, 1, pa, 1, "R3");
    send(pc, 3, pc, 11, "R3");
    drain("R3");
  endtask

  task automatic test_inverse();
    send(pb, 1, neg(pb), 1, "R4");
    send(pd, 5, neg(pd), 9, "R4");
    drain("R4");
  endtask

  task automatic test_identity();
    send(pa, 1, oo, 1, "R5");
    send(oo, 4, pc, 6, "R5");
    drain("R5");
  endtask

  task automatic test_inf_inf();
    send(oo, 1, oo, 1, "R6");
    send(oo, 5, oo, 12345, "R6");
    drain("R6");
  endtask

  task automatic test_scaling();
    send(pa, 1_000_003, pb, 77, "R8");
    send(pb, PM - 1, pd, 424242, "R8");
    drain("R8");
  endtask

  task automatic test_stream();
    send(pa, 1, pb, 2, "R1");
    send(pa, 3, pa, 3, "R3");
    send(pc, 1, neg(pc), 1, "R4");
    send(oo, 1, pd, 7, "R5");
    send(oo, 1, oo, 1, "R6");
    send(pb, 8, pc, 13, "R2");
    send(pd, 2, pd, 2, "R3");
    send(pa, 99, pd, 5, "R8");
    send(neg(pa), 1, pb, 1, "R2");
    send(pc, 6, oo, 2, "R5");
    drain("R1");
  endtask

  initial begin
    pa = find_point(2);
    pb = find_point(100);
    pc = find_point(5000);
    pd = find_point(77777);
    oo = '0; oo.inf = 1'b1;
    test_reset();
    test_general();
    test_double();
    test_inverse();
    test_identity();
    test_inf_inf();
    test_scaling();
    test_stream();
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      report();
    end
  end
endmodule